// File: doc/BRIEF.md
# Descriptor Ring with Done-Flag Interrupt

This block holds the descriptor rings that a processor shares with the transmit and receive DMA engines of an Ethernet MAC. Each direction has a ring of four entries. Every entry has a buffer address word, and the low five bits of that word hold flags because buffers sit on 32-byte boundaries. Software fills an entry and then sets its enable flag. The engine for that direction works on one entry at a time, in ring order, starting from the current-entry pointer. When the engine finishes an entry, the entry's done flag is set, its enable flag is cleared and the pointer moves on to the next entry. Transmit entries also carry a length word.

The single interrupt line is the OR of every done flag in both rings. No status register exists, so software scans the entries. The interrupt line can be used as a level source or as a rising-edge source. A done flag clears only when software writes a 0 to it. Reading any entry's address word also returns the pointer of its ring, so the driver can find the next entry without assuming a reset value.

The engine side of each direction is a valid/ready stream of descriptors. `*_desc_valid` presents the current entry. The engine takes it by raising `*_desc_ready`, and a cycle with both signals high counts as completion of that entry. The engine may hold ready low for as long as it needs, and the payload stays put while the entry and the run bit stay unchanged. Ready is ignored in any cycle where valid is low.

Top module: `dring_top`

## Requirements
- R1: After reset the control register reads 0, every enable and done flag is 0, `irq` is 0, every address and length word holds 0, and the pointers hold the parameter values `RX_PTR_RST` (default 2) and `TX_PTR_RST` (default 1).
- R2: Register index `reg_addr` = {ctrl, dir, entry[1:0], word}. ctrl=0 selects an entry, dir 0 is receive and 1 is transmit, word 0 is the address word and word 1 is the length word. The address word reads {buffer address [31:5], 0, pointer [3:2], done [1], enable [0]}. Every entry of a ring reports the same pointer, and bits 4:2 of a write are ignored.
- R3: A transmit length word stores and returns the low `LEN_W` bits. A receive length word always reads 0 and ignores writes.
- R4: In an address-word write, a 0 in bit 1 clears that entry's done flag and a 1 in bit 1 leaves it unchanged. Bit 0 writes the enable flag.
- R5: `*_desc_valid` is 1 exactly when the direction's run bit is set and the current entry has enable=1 and done=0. While it is 1, `*_desc_addr` is that entry's address with zero low bits, `*_desc_idx` is the pointer and `tx_desc_len` is the entry's length.
- R6: A cycle with valid and ready both high sets done, clears enable and advances the pointer by one modulo 4, all visible after that clock edge.
- R7: Ready while valid is low changes no pointer and no flag.
- R8: If the current entry is not enabled, or its done flag is still set, the ring stalls on it and never skips ahead to a later enabled entry.
- R9: `irq` equals the OR of all eight done flags.
- R10: The control register (`reg_addr` = 0x10) holds transmit run in bit 0 and receive run in bit 1. All other bits read 0.
- R11: Each ring runs only on its own run bit. One ring's handshakes and run bit leave the other ring untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register index (read and write) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| rx_desc_valid | output | 1 | Receive descriptor available |
| rx_desc_ready | input | 1 | Receive engine completes the presented entry |
| rx_desc_addr | output | 32 | Receive buffer address |
| rx_desc_idx | output | 2 | Receive entry index |
| tx_desc_valid | output | 1 | Transmit descriptor available |
| tx_desc_ready | input | 1 | Transmit engine completes the presented entry |
| tx_desc_addr | output | 32 | Transmit buffer address |
| tx_desc_len | output | LEN_W | Transmit buffer length |
| tx_desc_idx | output | 2 | Transmit entry index |
| irq | output | 1 | OR of all done flags |

## Verification
The assertions check these properties on every cycle: the pointer moves by exactly one after a handshake and holds still in every other cycle, the consumed entry ends up done and disabled, and a done flag rises only through a handshake on that entry. They also check that `irq` rises only after a handshake and falls only after a register write. Only the bench scenarios can show the rest: the exact descriptor payload, the no-skip stall when a later entry is enabled or the current one is still done, the write-1-ignored rule for the done bit, the receive length word ignoring writes, and the full wrap of each ring in turn.

// File: rtl/dring_pkg.sv
package dring_pkg;
  localparam int unsigned NUM_ENT    = 4;
  localparam int unsigned PTR_W      = $clog2(NUM_ENT);
  localparam int unsigned ALIGN_BITS = 5;
  localparam int unsigned DW         = 32;
  localparam int unsigned NUM_DIR    = 2;

  localparam int unsigned BIT_EN   = 0;
  localparam int unsigned BIT_DONE = 1;
  localparam int unsigned BIT_PTR  = 2;

  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } dring_dir_e;

  typedef struct packed {
    logic             ctrl;
    dring_dir_e       dir;
    logic [PTR_W-1:0] idx;
    logic             len_word;
  } dring_sel_t;
endpackage

// File: rtl/dring_ctrl.sv
module dring_ctrl
  import dring_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [4:0]           reg_addr,
  input  logic [DW-1:0]        reg_wdata,
  output dring_sel_t           sel,
  output logic [NUM_DIR-1:0]   ring_wr,
  output logic [NUM_DIR-1:0]   ring_run,
  output logic [DW-1:0]        ctrl_rdata
);
  logic tx_run_q, rx_run_q;

  assign sel = dring_sel_t'(reg_addr);

  always_comb begin
    ring_wr = '0;
    if (reg_wr && !sel.ctrl) ring_wr[sel.dir] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_run_q <= 1'b0;
      rx_run_q <= 1'b0;
    end else if (reg_wr && sel.ctrl) begin
      tx_run_q <= reg_wdata[0];
      rx_run_q <= reg_wdata[1];
    end
  end

  assign ring_run[DIR_TX] = tx_run_q;
  assign ring_run[DIR_RX] = rx_run_q;
  assign ctrl_rdata = {{(DW-2){1'b0}}, rx_run_q, tx_run_q};

  // R10: run bits change only through a control write
  p_run_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && sel.ctrl) |=> $stable(ring_run));
endmodule

// File: rtl/dring_ring.sv
module dring_ring
  import dring_pkg::*;
#(
  parameter int unsigned    LEN_W   = 16,
  parameter bit             HAS_LEN = 1'b1,
  parameter logic [PTR_W-1:0] PTR_RST = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_idx,
  input  logic             wr_len,
  input  logic [DW-1:0]    wr_data,
  input  logic [PTR_W-1:0] rd_idx,
  input  logic             rd_len,
  output logic [DW-1:0]    rd_data,
  output logic             desc_valid,
  input  logic             desc_ready,
  output logic [DW-1:0]    desc_addr,
  output logic [LEN_W-1:0] desc_len,
  output logic [PTR_W-1:0] desc_idx,
  output logic             done_any
);
  localparam int unsigned AHI = DW - ALIGN_BITS;

  logic [AHI-1:0]     addr_q [NUM_ENT];
  logic [NUM_ENT-1:0] en_q, done_q;
  logic [PTR_W-1:0]   ptr_q;
  logic [LEN_W-1:0]   len_rd, len_cur;
  logic               hs;

  assign desc_valid = run && en_q[ptr_q] && !done_q[ptr_q];
  assign hs         = desc_valid && desc_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ENT; i++) addr_q[i] <= '0;
      en_q   <= '0;
      done_q <= '0;
      ptr_q  <= PTR_RST;
    end else begin
      if (wr_en && !wr_len) begin
        addr_q[wr_idx] <= wr_data[DW-1:ALIGN_BITS];
        en_q[wr_idx]   <= wr_data[BIT_EN];
        if (!wr_data[BIT_DONE]) done_q[wr_idx] <= 1'b0;
      end
      if (hs) begin
        done_q[ptr_q] <= 1'b1;
        en_q[ptr_q]   <= 1'b0;
        ptr_q         <= ptr_q + 1'b1;
      end
    end
  end

  generate
    if (HAS_LEN) begin : g_len
      logic [LEN_W-1:0] len_q [NUM_ENT];
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int i = 0; i < NUM_ENT; i++) len_q[i] <= '0;
        end else if (wr_en && wr_len) begin
          len_q[wr_idx] <= wr_data[LEN_W-1:0];
        end
      end
      assign len_rd  = len_q[rd_idx];
      assign len_cur = len_q[ptr_q];
    end else begin : g_nolen
      assign len_rd  = '0;
      assign len_cur = '0;
    end
  endgenerate

  always_comb begin
    if (rd_len) begin
      rd_data = '0;
      rd_data[LEN_W-1:0] = len_rd;
    end else begin
      rd_data = {addr_q[rd_idx], ALIGN_BITS'(0)};
      rd_data[BIT_PTR +: PTR_W] = ptr_q;
      rd_data[BIT_DONE]         = done_q[rd_idx];
      rd_data[BIT_EN]           = en_q[rd_idx];
    end
  end

  assign desc_addr = {addr_q[ptr_q], ALIGN_BITS'(0)};
  assign desc_len  = len_cur;
  assign desc_idx  = ptr_q;
  assign done_any  = |done_q;

  // R6: pointer advances by one after a handshake
  p_ptr_adv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hs |=> ptr_q == PTR_W'($past(ptr_q) + 1'b1));
  // R6: consumed entry ends done and disabled
  p_consumed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hs |=> done_q[$past(ptr_q)] && !en_q[$past(ptr_q)]);
  // R7 / R8: no handshake, no pointer movement
  p_ptr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !hs |=> $stable(ptr_q));

  generate
    for (genvar e = 0; e < NUM_ENT; e++) begin : g_chk
      // R6: a done flag rises only when its entry is consumed
      p_done_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q[e]) |-> $past(hs && ptr_q == PTR_W'(e)));
    end
  endgenerate
endmodule

// File: rtl/dring_top.sv
module dring_top
  import dring_pkg::*;
#(
  parameter int unsigned LEN_W      = 16,
  parameter logic [1:0]  RX_PTR_RST = 2'd2,
  parameter logic [1:0]  TX_PTR_RST = 2'd1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [4:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             rx_desc_valid,
  input  logic             rx_desc_ready,
  output logic [31:0]      rx_desc_addr,
  output logic [1:0]       rx_desc_idx,
  output logic             tx_desc_valid,
  input  logic             tx_desc_ready,
  output logic [31:0]      tx_desc_addr,
  output logic [LEN_W-1:0] tx_desc_len,
  output logic [1:0]       tx_desc_idx,
  output logic             irq
);
  dring_sel_t         sel;
  logic [NUM_DIR-1:0] ring_wr, ring_run, d_valid, d_ready, d_done;
  logic [DW-1:0]      ctrl_rdata;
  logic [DW-1:0]      d_rdata [NUM_DIR];
  logic [DW-1:0]      d_addr  [NUM_DIR];
  logic [LEN_W-1:0]   d_len   [NUM_DIR];
  logic [PTR_W-1:0]   d_idx   [NUM_DIR];

  dring_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .sel        (sel),
    .ring_wr    (ring_wr),
    .ring_run   (ring_run),
    .ctrl_rdata (ctrl_rdata)
  );

  assign d_ready[DIR_RX] = rx_desc_ready;
  assign d_ready[DIR_TX] = tx_desc_ready;

  generate
    for (genvar d = 0; d < NUM_DIR; d++) begin : g_ring
      dring_ring #(
        .LEN_W   (LEN_W),
        .HAS_LEN (d == int'(DIR_TX)),
        .PTR_RST ((d == int'(DIR_TX)) ? TX_PTR_RST : RX_PTR_RST)
      ) u_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (ring_run[d]),
        .wr_en      (ring_wr[d]),
        .wr_idx     (sel.idx),
        .wr_len     (sel.len_word),
        .wr_data    (reg_wdata),
        .rd_idx     (sel.idx),
        .rd_len     (sel.len_word),
        .rd_data    (d_rdata[d]),
        .desc_valid (d_valid[d]),
        .desc_ready (d_ready[d]),
        .desc_addr  (d_addr[d]),
        .desc_len   (d_len[d]),
        .desc_idx   (d_idx[d]),
        .done_any   (d_done[d])
      );
    end
  endgenerate

  assign reg_rdata     = sel.ctrl ? ctrl_rdata : d_rdata[sel.dir];
  assign rx_desc_valid = d_valid[DIR_RX];
  assign rx_desc_addr  = d_addr[DIR_RX];
  assign rx_desc_idx   = d_idx[DIR_RX];
  assign tx_desc_valid = d_valid[DIR_TX];
  assign tx_desc_addr  = d_addr[DIR_TX];
  assign tx_desc_len   = d_len[DIR_TX];
  assign tx_desc_idx   = d_idx[DIR_TX];
  assign irq           = |d_done;

  // R9: interrupt rises only after some engine consumed an entry
  p_irq_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past((rx_desc_valid && rx_desc_ready) ||
                         (tx_desc_valid && tx_desc_ready)));
  // R4: interrupt falls only through a software write
  p_irq_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(reg_wr));
  // R11: a ring with its run bit clear never offers a descriptor
  p_tx_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!(reg_wr && reg_addr[4])) && !$past(tx_desc_valid) &&
    $past(reg_rdata[0] == 1'b0 && reg_addr == 5'h10) |-> !tx_desc_valid);
endmodule

// File: tb/dring_top_bench.sv
module dring_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic rx_desc_valid, rx_desc_ready = 1'b0, tx_desc_valid, tx_desc_ready = 1'b0;
  logic [31:0] rx_desc_addr, tx_desc_addr;
  logic [LEN_W-1:0] tx_desc_len;
  logic [1:0] rx_desc_idx, tx_desc_idx;
  logic irq;

  int n_tests = 0, n_fail = 0;

  logic [31:0] m_addr [2][4];
  logic [15:0] m_len [4];
  logic        m_en [2][4];
  logic        m_done [2][4];
  logic [1:0]  m_ptr [2];
  logic        m_run [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  dring_top #(.LEN_W(LEN_W)) u_dring_top (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rx_desc_valid(rx_desc_valid), .rx_desc_ready(rx_desc_ready),
    .rx_desc_addr(rx_desc_addr), .rx_desc_idx(rx_desc_idx),
    .tx_desc_valid(tx_desc_valid), .tx_desc_ready(tx_desc_ready),
    .tx_desc_addr(tx_desc_addr), .tx_desc_len(tx_desc_len),
    .tx_desc_idx(tx_desc_idx), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] ea(input int d, input int i, input int w);
    return {1'b0, d[0], i[1:0], w[0]};
  endfunction

  task automatic wr(input logic [4:0] a, input logic [31:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic wr_entry(input int d, input int i, input logic [31:0] v);
    wr(ea(d, i, 0), v);
    m_addr[d][i] = v & 32'hFFFF_FFE0;
    m_en[d][i] = v[0];
    if (!v[1]) m_done[d][i] = 1'b0;
  endtask

  task automatic set_run(input logic tx, input logic rx);
    wr(5'h10, {30'h0, rx, tx});
    m_run[1] = tx; m_run[0] = rx;
  endtask

  function automatic logic exp_valid(input int d);
    return m_run[d] && m_en[d][m_ptr[d]] && !m_done[d][m_ptr[d]];
  endfunction

  task automatic pulse(input int d);
    logic v;
    v = exp_valid(d);
    @(negedge clk);
    if (d == 1) tx_desc_ready = 1'b1; else rx_desc_ready = 1'b1;
    @(negedge clk);
    tx_desc_ready = 1'b0; rx_desc_ready = 1'b0;
    if (v) begin
      m_done[d][m_ptr[d]] = 1'b1;
      m_en[d][m_ptr[d]] = 1'b0;
      m_ptr[d] = m_ptr[d] + 2'd1;
    end
  endtask

  task automatic check_all(input string tag);
    logic [31:0] v;
    logic any;
    any = 1'b0;
    for (int d = 0; d < 2; d++) begin
      for (int i = 0; i < 4; i++) begin
        rd(ea(d, i, 0), v);
        chk({tag, " word"}, v, {m_addr[d][i][31:5], 1'b0, m_ptr[d], m_done[d][i], m_en[d][i]});
        any |= m_done[d][i];
      end
    end
    chk({tag, " R9 irq"}, {31'h0, irq}, {31'h0, any});
    chk({tag, " R5 rx valid"}, {31'h0, rx_desc_valid}, {31'h0, exp_valid(0)});
    chk({tag, " R5 tx valid"}, {31'h0, tx_desc_valid}, {31'h0, exp_valid(1)});
    if (exp_valid(0)) begin
      chk({tag, " R5 rx addr"}, rx_desc_addr, m_addr[0][m_ptr[0]]);
      chk({tag, " R5 rx idx"}, {30'h0, rx_desc_idx}, {30'h0, m_ptr[0]});
    end
    if (exp_valid(1)) begin
      chk({tag, " R5 tx addr"}, tx_desc_addr, m_addr[1][m_ptr[1]]);
      chk({tag, " R5 tx len"}, {16'h0, tx_desc_len}, {16'h0, m_len[m_ptr[1]]});
      chk({tag, " R5 tx idx"}, {30'h0, tx_desc_idx}, {30'h0, m_ptr[1]});
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [1:0] p0;
    for (int d = 0; d < 2; d++) begin
      for (int i = 0; i < 4; i++) begin
        m_addr[d][i] = '0; m_en[d][i] = 1'b0; m_done[d][i] = 1'b0;
      end
      m_run[d] = 1'b0;
    end
    for (int i = 0; i < 4; i++) m_len[i] = '0;
    m_ptr[0] = 2'd2; m_ptr[1] = 2'd1;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check_all("R1");
    rd(5'h10, v); chk("R1 ctrl", v, 32'h0);
    for (int i = 0; i < 4; i++) begin
      rd(ea(1, i, 1), v); chk("R1 tx len", v, 32'h0);
    end

    // R2 / R3 fill both rings
    for (int d = 0; d < 2; d++)
      for (int i = 0; i < 4; i++)
        wr_entry(d, i, 32'h2000_0000 + d * 32'h0100_0000 + i * 32'h60);
    for (int i = 0; i < 4; i++) begin
      wr(ea(1, i, 1), 32'hDEAD_0000 + 100 + i * 7);
      m_len[i] = 16'(100 + i * 7);
      rd(ea(1, i, 1), v); chk("R3 tx len", v, {16'h0, m_len[i]});
      wr(ea(0, i, 1), 32'h0000_ABCD);
      rd(ea(0, i, 1), v); chk("R3 rx len ignored", v, 32'h0);
    end
    wr_entry(1, 3, 32'h3000_0040 | 32'h1C);
    check_all("R2");

    // R10 control register
    wr(5'h10, 32'hFFFF_FFFF);
    rd(5'h10, v); chk("R10 ctrl", v, 32'h3);
    set_run(1'b1, 1'b0);
    rd(5'h10, v); chk("R10 ctrl tx", v, 32'h1);
    check_all("R8 idle");

    // R8 no skip: enable only the entry after the current one
    p0 = m_ptr[1];
    wr_entry(1, int'(p0 + 2'd1), m_addr[1][p0 + 2'd1] | 32'h1);
    check_all("R8 noskip");
    wr_entry(1, int'(p0), m_addr[1][p0] | 32'h1);
    check_all("R5 offer");

    // R11 rx entry enabled but RE off; R7 ready without valid
    wr_entry(0, int'(m_ptr[0]), m_addr[0][m_ptr[0]] | 32'h1);
    check_all("R11 rx gated");
    pulse(0);
    check_all("R7 rx ready ignored");

    // R6 consume two entries
    pulse(1); check_all("R6 first");
    pulse(1); check_all("R6 second");
    check_all("R8 stall disabled");
    for (int k = 0; k < 2; k++) begin
      wr_entry(1, int'(m_ptr[1]), m_addr[1][m_ptr[1]] | 32'h1);
      pulse(1);
      check_all("R6 wrap");
    end
    chk("R6 wrapped", {30'h0, m_ptr[1]}, {30'h0, p0});

    // R4 done write-1 keeps done; ring stalls on done entry (R8)
    wr_entry(1, int'(p0), m_addr[1][p0] | 32'h3);
    check_all("R4 keep done R8");
    wr_entry(1, int'(p0), m_addr[1][p0] | 32'h1);
    check_all("R4 clear done");
    pulse(1); check_all("R6 after clear");

    // R11 receive ring alone: full sweep
    set_run(1'b0, 1'b1);
    check_all("R11 rx run");
    for (int k = 0; k < 5; k++) begin
      if (!m_en[0][m_ptr[0]]) wr_entry(0, int'(m_ptr[0]), m_addr[0][m_ptr[0]] | 32'h1);
      pulse(0);
      check_all("R6 rx sweep");
    end
    wr_entry(1, int'(m_ptr[1]), (m_addr[1][m_ptr[1]] | 32'h1) & ~32'h2);
    pulse(1);
    check_all("R7 R11 tx ready while off");

    // R9 clear every done flag one by one
    for (int d = 0; d < 2; d++)
      for (int i = 0; i < 4; i++) begin
        wr_entry(d, i, m_addr[d][i]);
        check_all("R9 clear");
      end
    chk("R9 irq low", {31'h0, irq}, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule